// File: doc/BRIEF.md
# Cascadable 4-bit ALU slice

This block is a purely combinational arithmetic and logic slice. It takes two 4-bit operands, a carry input, a mode bit that picks logic or arithmetic operation, and a 4-bit function code. From these it produces a 4-bit result, a carry output, group propagate and group generate outputs, and a flag that is high when the result is all ones. The two modes together give 32 operations.

Each function code is decoded into two internal operand words, X and Y, with one bit of each per bit position. Arithmetic mode forms X + Y + carry_in. Logic mode forms the inverted XOR of X and Y, bit by bit. For X, the two low code bits add B or ~B terms to A. For Y, the two high code bits choose which A-and-B or A-and-not-B terms survive.

Wider ALUs are built from several slices. The carry output can feed the carry input of the next slice for ripple carry. The group propagate and generate outputs can instead feed an external lookahead unit. The all-ones flag from each slice can be ANDed to give a wide equality test.

Top module: `alu4_slice`

## Requirements
- R1: With logic_mode=1, every result bit is the inverse of X XOR Y at that bit. X = A | (func_sel[0] ? B : 0) | (func_sel[1] ? ~B : 0). Y = A & ((func_sel[3] ? B : 0) | (func_sel[2] ? ~B : 0)).
- R2: The named logic codes are: 4'b1011 gives A&B, 4'b1110 gives A|B, 4'b0110 gives A^B, 4'b1001 gives ~(A^B), 4'b0000 gives ~A, 4'b1111 gives A, 4'b0011 gives 0000, and 4'b1100 gives 1111.
- R3: With logic_mode=1, carry_in has no effect on result or on all_ones.
- R4: With logic_mode=0, result is the low 4 bits of X + Y + carry_in, where carry_in is active high.
- R5: The named arithmetic codes are: 4'b1001 gives A+B+c, 4'b0110 gives A-B-1+c, 4'b1100 gives A+A+c, 4'b0000 gives A+c, and 4'b1111 gives A-1+c (all modulo 16).
- R6: carry_out is bit 4 of X + Y + carry_in in both modes. grp_prop is 1 exactly when X is 1111. grp_gen is 1 exactly when X + Y is 16 or more. carry_out always equals grp_gen | (grp_prop & carry_in).
- R7: all_ones is 1 exactly when result is 1111. In arithmetic mode with code 4'b0110 and carry_in=0, this happens exactly when A equals B.
- R8: Two slices give the correct 8-bit sum in either of two setups. In the first, the upper slice's carry_in is the lower slice's carry_out. In the second, it is the lower slice's grp_gen | (grp_prop & carry_in).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | 4 | Operand A |
| op_b | input | 4 | Operand B |
| carry_in | input | 1 | Active-high carry into bit 0 |
| logic_mode | input | 1 | 1 selects logic mode, 0 selects arithmetic mode |
| func_sel | input | 4 | Function code |
| result | output | 4 | Operation result |
| carry_out | output | 1 | Carry out of bit 3 |
| grp_prop | output | 1 | Group propagate for lookahead |
| grp_gen | output | 1 | Group generate for lookahead |
| all_ones | output | 1 | High when result is 1111 |

## Verification
Every output of the slice is combinational. Each result is therefore due in the same clock cycle as the stimulus that causes it, with zero register stages. The driver changes the inputs 1 ns after a rising edge and places the expected item in the scoreboard queue. The monitor takes that item off the queue at the following falling edge, after the inputs have settled, so each comparison covers exactly one stimulus. In the two-slice setups, the upper slice's carry comes through the same combinational path and is sampled at that same falling edge.

// File: rtl/alu_slice_pkg.sv
package alu_slice_pkg;

  typedef logic [3:0] fsel_t;

  // Named function codes
  localparam fsel_t FS_LG_NOT_A = 4'b0000;
  localparam fsel_t FS_LG_XOR   = 4'b0110;
  localparam fsel_t FS_LG_XNOR  = 4'b1001;
  localparam fsel_t FS_LG_AND   = 4'b1011;
  localparam fsel_t FS_LG_OR    = 4'b1110;
  localparam fsel_t FS_LG_A     = 4'b1111;
  localparam fsel_t FS_LG_ZERO  = 4'b0011;
  localparam fsel_t FS_LG_ONES  = 4'b1100;
  localparam fsel_t FS_AR_ADD   = 4'b1001;
  localparam fsel_t FS_AR_SUBM1 = 4'b0110;
  localparam fsel_t FS_AR_DBL   = 4'b1100;
  localparam fsel_t FS_AR_INC   = 4'b0000;
  localparam fsel_t FS_AR_DEC   = 4'b1111;

  // Per-bit operand terms: {x, y}; y is only ever set where x is set.
  function automatic logic [1:0] bit_terms(input logic a, input logic b, input fsel_t sel);
    logic x;
    logic y;
    x = a | (sel[0] & b) | (sel[1] & ~b);
    y = a & ((sel[3] & b) | (sel[2] & ~b));
    return {x, y};
  endfunction

  // Per-bit result: half-sum of the terms, then carry (arith) or inversion (logic).
  function automatic logic out_bit(input logic x, input logic y, input logic c,
                                   input logic logic_sel);
    return (x ^ y) ^ (logic_sel ? 1'b1 : c);
  endfunction

endpackage

// File: rtl/alu_bit_terms.sv
module alu_bit_terms
  import alu_slice_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  input  fsel_t            sel,
  output logic [WIDTH-1:0] x_word,
  output logic [WIDTH-1:0] y_word
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic [1:0] t;
    assign t         = bit_terms(a_in[i], b_in[i], sel);
    assign x_word[i] = t[1];
    assign y_word[i] = t[0];
  end

endmodule

// File: rtl/alu_carry_net.sv
module alu_carry_net #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] x_word,
  input  logic [WIDTH-1:0] y_word,
  input  logic             cin,
  output logic [WIDTH-1:0] bit_carry,
  output logic             cout,
  output logic             grp_p,
  output logic             grp_g
);

  logic [WIDTH:0] chain;

  // Ripple chain: carry into each bit
  assign chain[0] = cin;
  for (genvar i = 0; i < WIDTH; i++) begin : g_ripple
    assign chain[i+1] = y_word[i] | (x_word[i] & chain[i]);
  end
  assign bit_carry = chain[WIDTH-1:0];
  assign cout      = chain[WIDTH];

  // Group terms in lookahead sum-of-products form
  always_comb begin
    logic run;
    run   = 1'b1;
    grp_g = 1'b0;
    for (int i = WIDTH - 1; i >= 0; i--) begin
      grp_g = grp_g | (y_word[i] & run);
      run   = run & x_word[i];
    end
    grp_p = run;
  end

  // R6: ripple carry-out agrees with the lookahead group terms
  always_comb begin
    assert_cout_lookahead_R6: assert (cout == (grp_g | (grp_p & cin)))
      else $error("R6 ripple/lookahead carry mismatch");
    assert_gen_forces_carry_R6: assert (!grp_g || cout)
      else $error("R6 generate without carry-out");
  end

endmodule

// File: rtl/alu_result_stage.sv
module alu_result_stage
  import alu_slice_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] x_word,
  input  logic [WIDTH-1:0] y_word,
  input  logic [WIDTH-1:0] bit_carry,
  input  logic             logic_sel,
  output logic [WIDTH-1:0] res,
  output logic             res_ones
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_out
    assign res[i] = out_bit(x_word[i], y_word[i], bit_carry[i], logic_sel);
  end

  assign res_ones = &res;

endmodule

// File: rtl/alu4_slice.sv
module alu4_slice
  import alu_slice_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             carry_in,
  input  logic             logic_mode,
  input  logic [3:0]       func_sel,
  output logic [WIDTH-1:0] result,
  output logic             carry_out,
  output logic             grp_prop,
  output logic             grp_gen,
  output logic             all_ones
);

  localparam int SUM_W = WIDTH + 1;

  logic [WIDTH-1:0] x_word;
  logic [WIDTH-1:0] y_word;
  logic [WIDTH-1:0] bit_carry;

  alu_bit_terms #(.WIDTH(WIDTH)) u_terms (
    .a_in   (op_a),
    .b_in   (op_b),
    .sel    (func_sel),
    .x_word (x_word),
    .y_word (y_word)
  );

  alu_carry_net #(.WIDTH(WIDTH)) u_carry (
    .x_word    (x_word),
    .y_word    (y_word),
    .cin       (carry_in),
    .bit_carry (bit_carry),
    .cout      (carry_out),
    .grp_p     (grp_prop),
    .grp_g     (grp_gen)
  );

  alu_result_stage #(.WIDTH(WIDTH)) u_result (
    .x_word    (x_word),
    .y_word    (y_word),
    .bit_carry (bit_carry),
    .logic_sel (logic_mode),
    .res       (result),
    .res_ones  (all_ones)
  );

  // Port-level checks of named operations
  logic [SUM_W-1:0] add_ref;
  assign add_ref = {1'b0, op_a} + {1'b0, op_b} + SUM_W'(carry_in);

  always_comb begin
    if (!logic_mode && func_sel == FS_AR_ADD)
      assert_add_R5: assert ({carry_out, result} == add_ref)
        else $error("R5 add mismatch");
    if (logic_mode && func_sel == FS_LG_XOR)
      assert_logic_xor_R2: assert (result == (op_a ^ op_b))
        else $error("R2 xor mismatch");
    if (logic_mode && func_sel == FS_LG_A)
      assert_logic_pass_R2: assert (result == op_a)
        else $error("R2 pass mismatch");
    if (!logic_mode && func_sel == FS_AR_SUBM1 && !carry_in)
      assert_equal_flag_R7: assert (all_ones == (op_a == op_b))
        else $error("R7 equality flag mismatch");
  end

endmodule

// File: tb/sim_alu4_slice.sv
`timescale 1ns/1ps
module sim_alu4_slice;

  localparam int MAX_CYCLES = 40000;

  typedef struct {
    logic [3:0] a, b, sel;
    logic       cin, lm;
    logic [3:0] ef;
    logic       eco, ep, eg, eeq;
    bit         hi_valid;
    logic [8:0] esum;
    bit         la_mode;
    string      tag;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [3:0] a_in = '0, b_in = '0, sel_in = '0;
  logic       cin_in = 1'b0, lm_in = 1'b0;
  logic [3:0] res0, res1, hi_a = '0, hi_b = '0;
  logic       co0, p0, g0, eq0, co1, p1, g1, eq1, hi_cin;
  logic       use_la = 1'b0;

  alu4_slice u0 (
    .op_a(a_in), .op_b(b_in), .carry_in(cin_in), .logic_mode(lm_in),
    .func_sel(sel_in), .result(res0), .carry_out(co0),
    .grp_prop(p0), .grp_gen(g0), .all_ones(eq0)
  );

  assign hi_cin = use_la ? (g0 | (p0 & cin_in)) : co0;

  alu4_slice u1 (
    .op_a(hi_a), .op_b(hi_b), .carry_in(hi_cin), .logic_mode(1'b0),
    .func_sel(4'b1001), .result(res1), .carry_out(co1),
    .grp_prop(p1), .grp_gen(g1), .all_ones(eq1)
  );

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;
  item_t sb[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  // Independent model, written on whole words
  function automatic item_t model(input logic [3:0] a, input logic [3:0] b,
                                  input logic cin, input logic lm,
                                  input logic [3:0] sel, input string tag);
    item_t it;
    int xv, yv, nb, sum;
    nb  = (~b) & 15;
    xv  = a | (sel[0] ? b : 0) | (sel[1] ? nb : 0);
    yv  = a & ((sel[3] ? b : 0) | (sel[2] ? nb : 0));
    sum = xv + yv + cin;
    it.a = a; it.b = b; it.cin = cin; it.lm = lm; it.sel = sel;
    it.ef  = lm ? 4'((~(xv ^ yv)) & 15) : 4'(sum & 15);
    it.eco = sum > 15;
    it.ep  = (xv == 15);
    it.eg  = (xv + yv) > 15;
    it.eeq = (it.ef == 4'hF);
    it.hi_valid = 1'b0;
    it.esum = '0;
    it.la_mode = 1'b0;
    it.tag = tag;
    return it;
  endfunction

  task automatic drive(input item_t it, input logic [3:0] ha, input logic [3:0] hb);
    @(posedge clk);
    #1;
    a_in = it.a; b_in = it.b; cin_in = it.cin; lm_in = it.lm; sel_in = it.sel;
    hi_a = ha; hi_b = hb; use_la = it.la_mode;
    sb.push_back(it);
  endtask

  // Monitor: results are combinational, due in the cycle of the stimulus
  initial begin
    forever begin
      @(negedge clk);
      if (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        chk(res0 == it.ef, it.tag, "result", res0, it.ef);
        chk(co0 == it.eco, "R6", "carry_out", co0, it.eco);
        chk(p0 == it.ep, "R6", "grp_prop", p0, it.ep);
        chk(g0 == it.eg, "R6", "grp_gen", g0, it.eg);
        chk(eq0 == it.eeq, "R7", "all_ones", eq0, it.eeq);
        if (it.hi_valid)
          chk({co1, res1, res0} == it.esum, "R8", "cascade sum",
              {co1, res1, res0}, it.esum);
      end
    end
  end

  function automatic logic [3:0] named_logic(input logic [3:0] s, input logic [3:0] a,
                                             input logic [3:0] b);
    case (s)
      4'b1011: return a & b;
      4'b1110: return a | b;
      4'b0110: return a ^ b;
      4'b1001: return ~(a ^ b);
      4'b0000: return ~a;
      4'b1111: return a;
      4'b0011: return 4'h0;
      default: return 4'hF;
    endcase
  endfunction

  function automatic logic [3:0] named_arith(input logic [3:0] s, input logic [3:0] a,
                                             input logic [3:0] b, input logic c);
    case (s)
      4'b1001: return a + b + 4'(c);
      4'b0110: return a - b - 4'd1 + 4'(c);
      4'b1100: return a + a + 4'(c);
      4'b0000: return a + 4'(c);
      default: return a - 4'd1 + 4'(c);
    endcase
  endfunction

  initial begin
    item_t it;
    logic [3:0] lcodes [8];
    logic [3:0] acodes [5];
    lcodes = '{4'b1011, 4'b1110, 4'b0110, 4'b1001, 4'b0000, 4'b1111, 4'b0011, 4'b1100};
    acodes = '{4'b1001, 4'b0110, 4'b1100, 4'b0000, 4'b1111};
    repeat (4) @(posedge clk);
    rst_n = 1'b1;

    // Reset-state check: all inputs zero, arithmetic code 0000 -> all outputs 0 (R4)
    it = model(4'h0, 4'h0, 1'b0, 1'b0, 4'h0, "R4 reset-state");
    drive(it, 4'h0, 4'h0);

    // Exhaustive sweep of both modes (R1, R3 in logic; R4 in arithmetic)
    for (int lm = 0; lm < 2; lm++)
      for (int s = 0; s < 16; s++)
        for (int c = 0; c < 2; c++)
          for (int a = 0; a < 16; a++)
            for (int b = 0; b < 16; b++) begin
              it = model(4'(a), 4'(b), 1'(c), 1'(lm), 4'(s),
                         lm ? "R1 R3 logic" : "R4 arith");
              drive(it, 4'h0, 4'h0);
            end

    // Named logic codes (R2); carry toggled to show no effect (R3)
    for (int k = 0; k < 8; k++)
      for (int a = 0; a < 16; a += 3)
        for (int b = 0; b < 16; b += 5)
          for (int c = 0; c < 2; c++) begin
            it = model(4'(a), 4'(b), 1'(c), 1'b1, lcodes[k], "R2 named logic");
            it.ef  = named_logic(lcodes[k], 4'(a), 4'(b));
            it.eeq = (it.ef == 4'hF);
            drive(it, 4'h0, 4'h0);
          end

    // Named arithmetic codes (R5)
    for (int k = 0; k < 5; k++)
      for (int a = 0; a < 16; a += 3)
        for (int b = 0; b < 16; b += 5)
          for (int c = 0; c < 2; c++) begin
            it = model(4'(a), 4'(b), 1'(c), 1'b0, acodes[k], "R5 named arith");
            it.ef  = named_arith(acodes[k], 4'(a), 4'(b), 1'(c));
            it.eeq = (it.ef == 4'hF);
            drive(it, 4'h0, 4'h0);
          end

    // Equality flag through subtract-minus-one, carry 0 (R7)
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b += 7) begin
        it = model(4'(a), 4'(b), 1'b0, 1'b0, 4'b0110, "R7 equality");
        it.eeq = (a == b);
        drive(it, 4'h0, 4'h0);
        it = model(4'(a), 4'(a), 1'b0, 1'b0, 4'b0110, "R7 equality");
        it.eeq = 1'b1;
        drive(it, 4'h0, 4'h0);
      end

    // Two-slice cascade, ripple and lookahead carry (R8)
    for (int la = 0; la < 2; la++)
      for (int av = 0; av < 256; av += 37)
        for (int bv = 0; bv < 256; bv += 29)
          for (int c = 0; c < 2; c++) begin
            it = model(4'(av), 4'(bv), 1'(c), 1'b0, 4'b1001, "R8 cascade low");
            it.hi_valid = 1'b1;
            it.la_mode  = 1'(la);
            it.esum     = 9'(av + bv + c);
            drive(it, 4'(av >> 4), 4'(bv >> 4));
          end

    while (sb.size() > 0) @(posedge clk);
    @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // Watchdog
  initial begin
    repeat (MAX_CYCLES) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog act=%0d exp=%0d", MAX_CYCLES, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule